// File: doc/BRIEF.md
# Flash Row-Write Buffer Controller

This block sits between a processor's register-write port and a program flash array. Software writes an address and a 14-bit data word, unlocks the block with a two-value key, and then sets a start bit. Each accepted start copies the data word into one of four holding registers, which the two low address bits select. When the word goes into the last slot of an aligned four-word row, the block commits the whole row to flash in one write. It also holds the processor in a stall for a parameterized number of cycles, which stands for the flash programming time.

Rows that fall in a segment chosen by two write-protect configuration inputs are never written to flash. After every row commit the holding registers return to the erased value 0x3FFF. The stall request is a separate output from the write-in-progress flag. It rises one cycle after the start is accepted, so the processor can finish one more instruction before it halts.

Top module: `rowbuf_flash_ctrl`

## Requirements
- R1: After reset, `wr_busy`, `stall_req` and `fl_we` are low and all four holding registers hold 0x3FFF.
- R2: A control write (`reg_sel`=0) with start bit 0 set takes effect only when the key register (`reg_sel`=3) was last written with 0x55 and then with 0xAA. Without that it has no effect.
- R3: A key write of 0x55 always restarts the unlock sequence. Any other key value that does not complete 0x55 then 0xAA clears it.
- R4: Each control write with the start bit set uses up the unlock, whether or not the start is accepted.
- R5: A start is accepted only if the same control write has write-enable (bit 1) and program-memory select (bit 3) set and erase select (bit 2) clear.
- R6: An accepted start whose address bits [1:0] are not 11 copies the data word into the holding slot selected by those bits. `wr_busy` is high for exactly one cycle. There is no stall and no flash write.
- R7: An accepted start with address bits [1:0] = 11 loads slot 3 and then issues a single-cycle `fl_we`. `fl_row_addr` is the address without its two low bits, and slot k appears in `fl_row_data[14k+13:14k]`.
- R8: For an unprotected row commit, `stall_req` is low in the cycle after the accepting clock edge. It rises on the next edge, together with `fl_we`, and stays high for exactly STALL_CYCLES cycles.
- R9: `wr_busy` rises on the accepting edge, stays high throughout the stall, and falls on the same edge as `stall_req`.
- R10: After every row commit, including a blocked one, all four holding registers read back as 0x3FFF.
- R11: Write protection, from `prot_cfg`: 11 protects nothing, 10 protects addresses whose top three bits are zero, 01 protects addresses whose top bit is zero, 00 protects everything. A row commit to a protected address gives no `fl_we` and no stall, and `wr_busy` is high for one cycle. Loading a slot is not affected by protection.
- R12: Register writes of any kind are ignored while `wr_busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 address, 2 data, 3 key |
| reg_wdata | input | 16 | Register write data |
| prot_cfg | input | 2 | Write-protect configuration |
| fl_we | output | 1 | One-cycle flash row write strobe |
| fl_row_addr | output | ADDR_W-2 | Row address of the committed row |
| fl_row_data | output | 4*WORD_W | Four words of the row, slot 0 in the low bits |
| wr_busy | output | 1 | Start bit readback: write in progress |
| stall_req | output | 1 | Processor stall request during a row commit |

## Verification
The bench goes after the unlock corner cases: a broken key pair, a repeated 0x55 before 0xAA, and a rejected start that still uses up the key. A design that kept the unlock alive after a rejected start would accept a second start that it should refuse. It checks rows where only some slots were written and rows written straight after a commit. A design that failed to reset the buffers would then leak stale words into the next row. Protected commits are checked for a missing strobe and a missing stall, but with the buffer reset still done. Writes issued during a stall must change neither the address, the data nor the unlock state. A design that let them through would commit the wrong row or accept a start without a key.

// File: rtl/rowbuf_pkg.sv
package rowbuf_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_DATA = 2'd2,
    SEL_KEY  = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    UL_IDLE  = 2'd0,
    UL_HALF  = 2'd1,
    UL_ARMED = 2'd2
  } unlock_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_LATCH = 2'd1,
    SQ_PROG  = 2'd2
  } seq_e;

  localparam int CB_START = 0;
  localparam int CB_WREN  = 1;
  localparam int CB_ERASE = 2;
  localparam int CB_PGM   = 3;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;
endpackage

// File: rtl/rowbuf_unlock.sv
module rowbuf_unlock
  import rowbuf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_we,
  input  logic [7:0] key_val,
  input  logic       consume,
  output logic       armed
);
  unlock_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (consume) begin
      st_d = UL_IDLE;
    end else if (key_we) begin
      if (key_val == KEY_FIRST) begin
        st_d = UL_HALF;
      end else if (st_q == UL_HALF && key_val == KEY_SECOND) begin
        st_d = UL_ARMED;
      end else begin
        st_d = UL_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= UL_IDLE;
    else        st_q <= st_d;
  end

  assign armed = (st_q == UL_ARMED);
endmodule

// File: rtl/rowbuf_holding.sv
module rowbuf_holding #(
  parameter int WORD_W = 14,
  parameter int NWORDS = 4,
  localparam int SLOT_W = $clog2(NWORDS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ld_en,
  input  logic [SLOT_W-1:0]        ld_slot,
  input  logic [WORD_W-1:0]        ld_word,
  input  logic                     clr,
  output logic [NWORDS*WORD_W-1:0] row
);
  localparam logic [WORD_W-1:0] ERASED = {WORD_W{1'b1}};

  for (genvar g = 0; g < NWORDS; g++) begin : g_slot
    logic [WORD_W-1:0] word_q, word_d;
    logic              en;

    assign en = clr || (ld_en && ld_slot == SLOT_W'(g));

    always_comb begin
      word_d = clr ? ERASED : ld_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  word_q <= ERASED;
      else if (en) word_q <= word_d;
    end

    assign row[g*WORD_W +: WORD_W] = word_q;
  end
endmodule

// File: rtl/rowbuf_seq.sv
module rowbuf_seq
  import rowbuf_pkg::*;
#(
  parameter int STALL_CYCLES = 40,
  localparam int CNT_W = $clog2(STALL_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic slot_last,
  input  logic prot_hit,
  output logic busy,
  output logic stall,
  output logic prog_we,
  output logic ld_en,
  output logic clr_buf
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STALL_CYCLES - 1);

  seq_e             st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    ld_en   = 1'b0;
    clr_buf = 1'b0;
    prog_we = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        if (go) st_d = SQ_LATCH;
      end
      SQ_LATCH: begin
        ld_en = 1'b1;
        if (!slot_last) begin
          st_d = SQ_IDLE;
        end else if (prot_hit) begin
          clr_buf = 1'b1;
          st_d    = SQ_IDLE;
        end else begin
          cnt_d  = '0;
          cnt_en = 1'b1;
          st_d   = SQ_PROG;
        end
      end
      SQ_PROG: begin
        prog_we = (cnt_q == '0);
        cnt_en  = 1'b1;
        if (cnt_q == CNT_LAST) begin
          clr_buf = 1'b1;
          st_d    = SQ_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SQ_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy  = (st_q != SQ_IDLE);
  assign stall = (st_q == SQ_PROG);
endmodule

// File: rtl/rowbuf_flash_ctrl.sv
module rowbuf_flash_ctrl
  import rowbuf_pkg::*;
#(
  parameter int ADDR_W       = 13,
  parameter int WORD_W       = 14,
  parameter int WDATA_W      = 16,
  parameter int STALL_CYCLES = 40,
  localparam int NWORDS = 4,
  localparam int SLOT_W = $clog2(NWORDS),
  localparam int ROW_W  = ADDR_W - SLOT_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_we,
  input  logic [1:0]               reg_sel,
  input  logic [WDATA_W-1:0]       reg_wdata,
  input  logic [1:0]               prot_cfg,
  output logic                     fl_we,
  output logic [ROW_W-1:0]         fl_row_addr,
  output logic [NWORDS*WORD_W-1:0] fl_row_data,
  output logic                     wr_busy,
  output logic                     stall_req
);
  logic       rst_meta, rst_int;
  logic       idle_we;
  logic       addr_en, data_en, key_we, start_req, go, armed;
  logic       prot_hit, ld_en, clr_buf, seq_busy;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_int  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_int  <= rst_meta;
    end
  end

  assign idle_we   = reg_we && !seq_busy;
  assign addr_en   = idle_we && (reg_sel == SEL_ADDR);
  assign data_en   = idle_we && (reg_sel == SEL_DATA);
  assign key_we    = idle_we && (reg_sel == SEL_KEY);
  assign start_req = idle_we && (reg_sel == SEL_CTRL) && reg_wdata[CB_START];
  assign go = start_req && armed && reg_wdata[CB_WREN] &&
              reg_wdata[CB_PGM] && !reg_wdata[CB_ERASE];

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int)     addr_q <= '0;
    else if (addr_en) addr_q <= reg_wdata[ADDR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int)     data_q <= '0;
    else if (data_en) data_q <= reg_wdata[WORD_W-1:0];
  end

  always_comb begin
    unique case (prot_cfg)
      2'b11:   prot_hit = 1'b0;
      2'b10:   prot_hit = (addr_q[ADDR_W-1:ADDR_W-3] == 3'b000);
      2'b01:   prot_hit = !addr_q[ADDR_W-1];
      default: prot_hit = 1'b1;
    endcase
  end

  rowbuf_unlock u_unlock (
    .clk     (clk),
    .rst_n   (rst_int),
    .key_we  (key_we),
    .key_val (reg_wdata[7:0]),
    .consume (start_req),
    .armed   (armed)
  );

  rowbuf_seq #(.STALL_CYCLES(STALL_CYCLES)) u_seq (
    .clk       (clk),
    .rst_n     (rst_int),
    .go        (go),
    .slot_last (&addr_q[SLOT_W-1:0]),
    .prot_hit  (prot_hit),
    .busy      (seq_busy),
    .stall     (stall_req),
    .prog_we   (fl_we),
    .ld_en     (ld_en),
    .clr_buf   (clr_buf)
  );

  rowbuf_holding #(.WORD_W(WORD_W), .NWORDS(NWORDS)) u_hold (
    .clk     (clk),
    .rst_n   (rst_int),
    .ld_en   (ld_en),
    .ld_slot (addr_q[SLOT_W-1:0]),
    .ld_word (data_q),
    .clr     (clr_buf),
    .row     (fl_row_data)
  );

  assign fl_row_addr = addr_q[ADDR_W-1:SLOT_W];
  assign wr_busy     = seq_busy;
endmodule

// File: rtl/rowbuf_flash_ctrl_chk.sv
module rowbuf_flash_ctrl_chk #(
  parameter int STALL_CYCLES = 40,
  localparam int RUN_W = $clog2(STALL_CYCLES + 1) + 1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_we,
  input logic [1:0] reg_sel,
  input logic       fl_we,
  input logic       stall_req,
  input logic       wr_busy
);
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         run_q <= '0;
    else if (stall_req) run_q <= run_q + 1'b1;
    else                run_q <= '0;
  end

  assert_we_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fl_we |=> !fl_we);

  assert_we_in_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall_req) |-> fl_we);

  assert_stall_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stall_req |-> (run_q < RUN_W'(STALL_CYCLES)));

  assert_stall_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stall_req) |-> (run_q == RUN_W'(STALL_CYCLES)));

  assert_busy_covers_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stall_req |-> wr_busy);

  assert_busy_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stall_req) |-> !wr_busy);

  assert_start_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_busy) |-> $past(reg_we && reg_sel == 2'd0));
endmodule

bind rowbuf_flash_ctrl rowbuf_flash_ctrl_chk #(.STALL_CYCLES(STALL_CYCLES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .reg_sel   (reg_sel),
  .fl_we     (fl_we),
  .stall_req (stall_req),
  .wr_busy   (wr_busy)
);

// File: tb/rowbuf_flash_ctrl_bench.sv
module rowbuf_flash_ctrl_bench;
  localparam int ADDR_W = 13;
  localparam int WORD_W = 14;
  localparam int STALL  = 24;
  localparam logic [15:0] CTRL_OK = 16'h000B;

  logic        clk;
  logic        rst_n;
  logic        reg_we;
  logic [1:0]  reg_sel;
  logic [15:0] reg_wdata;
  logic [1:0]  prot_cfg;
  logic        fl_we;
  logic [ADDR_W-3:0] fl_row_addr;
  logic [4*WORD_W-1:0] fl_row_data;
  logic        wr_busy;
  logic        stall_req;

  int checks = 0;
  int fails  = 0;
  int we_seen = 0;
  int we_exp  = 0;
  bit done = 0;

  logic [WORD_W-1:0] m_buf [4];
  logic [ADDR_W-1:0] m_addr;
  logic [WORD_W-1:0] m_data;
  int                m_arm;

  rowbuf_flash_ctrl #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .WDATA_W(16),
                      .STALL_CYCLES(STALL)) u_rowbuf_flash_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .prot_cfg(prot_cfg), .fl_we(fl_we),
    .fl_row_addr(fl_row_addr), .fl_row_data(fl_row_data),
    .wr_busy(wr_busy), .stall_req(stall_req)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) if (fl_we) we_seen++;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual expired expected finished");
      summary();
    end
  end

  function automatic bit prot_f(input logic [1:0] p, input logic [ADDR_W-1:0] a);
    case (p)
      2'b11:   return 1'b0;
      2'b10:   return a[ADDR_W-1:ADDR_W-3] == 3'b000;
      2'b01:   return !a[ADDR_W-1];
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [4*WORD_W-1:0] row_f();
    return {m_buf[3], m_buf[2], m_buf[1], m_buf[0]};
  endfunction

  task automatic erase_model();
    for (int i = 0; i < 4; i++) m_buf[i] = 14'h3FFF;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] val);
    @(negedge clk);
    reg_we = 1'b1;
    reg_sel = sel;
    reg_wdata = val;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic set_addr(input logic [ADDR_W-1:0] a);
    wr(2'd1, 16'(a));
    m_addr = a;
  endtask

  task automatic set_data(input logic [WORD_W-1:0] d);
    wr(2'd2, 16'(d));
    m_data = d;
  endtask

  task automatic key(input logic [7:0] v);
    wr(2'd3, {8'h00, v});
    if (v == 8'h55) m_arm = 1;
    else if (m_arm == 1 && v == 8'hAA) m_arm = 2;
    else m_arm = 0;
  endtask

  task automatic unlock();
    key(8'h55);
    key(8'hAA);
  endtask

  // Control write with model-predicted outcome; req names the tag to report.
  task automatic start(input logic [15:0] cv, input string req);
    bit acc;
    int n;
    acc = cv[0] && m_arm == 2 && cv[1] && cv[3] && !cv[2];
    if (cv[0]) m_arm = 0;
    wr(2'd0, cv);
    chk(wr_busy == acc, req, "busy after control write", 64'(wr_busy), 64'(acc));
    if (acc) begin
      chk(stall_req == 1'b0, "R8", "stall one cycle late", 64'(stall_req), 64'd0);
      if (m_addr[1:0] != 2'b11) begin
        m_buf[m_addr[1:0]] = m_data;
        @(negedge clk);
        chk(!wr_busy && !stall_req, "R6", "short write busy/stall",
            64'({wr_busy, stall_req}), 64'd0);
      end else if (prot_f(prot_cfg, m_addr)) begin
        erase_model();
        @(negedge clk);
        chk(!wr_busy && !stall_req && !fl_we, "R11", "protected commit",
            64'({wr_busy, stall_req, fl_we}), 64'd0);
      end else begin
        m_buf[3] = m_data;
        @(negedge clk);
        chk(stall_req && fl_we, "R8", "stall and strobe rise",
            64'({stall_req, fl_we}), 64'd3);
        chk(fl_row_data == row_f(), "R7", "row data", 64'(fl_row_data), 64'(row_f()));
        chk(fl_row_addr == m_addr[ADDR_W-1:2], "R7", "row address",
            64'(fl_row_addr), 64'(m_addr[ADDR_W-1:2]));
        n = 1;
        while (stall_req && n < 1000) begin
          chk(wr_busy, "R9", "busy during stall", 64'(wr_busy), 64'd1);
          @(negedge clk);
          if (stall_req) n++;
        end
        chk(n == STALL, "R8", "stall length", 64'(n), 64'(STALL));
        chk(!wr_busy, "R9", "busy falls with stall", 64'(wr_busy), 64'd0);
        we_exp++;
        erase_model();
      end
    end
    @(negedge clk);
    chk(we_seen == we_exp, req, "flash strobe count", 64'(we_seen), 64'(we_exp));
  endtask

  // Unlock, then load one slot (short or long).
  task automatic put(input logic [ADDR_W-1:0] a, input logic [WORD_W-1:0] d,
                     input string req);
    set_addr(a);
    set_data(d);
    unlock();
    start(CTRL_OK, req);
  endtask

  initial begin
    void'($urandom(32'd5150));
    rst_n = 1'b0;
    reg_we = 1'b0;
    reg_sel = '0;
    reg_wdata = '0;
    prot_cfg = 2'b11;
    m_addr = '0;
    m_data = '0;
    m_arm = 0;
    erase_model();
    repeat (3) @(negedge clk);
    chk(!wr_busy && !stall_req && !fl_we, "R1", "reset outputs",
        64'({wr_busy, stall_req, fl_we}), 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: first commit shows erased slots 0..2
    put(13'h0013, 14'h1234, "R1");
    // R7: full row
    put(13'h0100, 14'h0AAA, "R6");
    put(13'h0101, 14'h1555, "R6");
    put(13'h0102, 14'h2001, "R6");
    put(13'h0103, 14'h3FFE, "R7");
    // R10: next row only slot 3 written
    put(13'h0107, 14'h0042, "R10");

    // R2: no unlock
    set_addr(13'h0200); set_data(14'h0111);
    start(CTRL_OK, "R2");
    // R3: broken sequence
    key(8'h55); key(8'h12); key(8'hAA);
    start(CTRL_OK, "R3");
    key(8'hAA); key(8'h55);
    start(CTRL_OK, "R3");
    // R3: repeated first key restarts
    key(8'h55); key(8'h55); key(8'hAA);
    start(CTRL_OK, "R3");
    // R4: unlock used up by accepted start
    start(CTRL_OK, "R4");
    // R4/R5: rejected start still consumes
    unlock();
    start(16'h0009, "R5");
    start(CTRL_OK, "R4");
    unlock(); start(16'h000F, "R5");
    unlock(); start(16'h0003, "R5");
    unlock(); start(16'h000A, "R2");
    // R2: control write without start keeps unlock
    unlock(); wr(2'd0, 16'h000A); start(CTRL_OK, "R2");
    set_addr(13'h0203);
    unlock(); start(CTRL_OK, "R6");

    // R11: protection modes
    prot_cfg = 2'b10;
    put(13'h0300, 14'h0777, "R11");
    put(13'h0303, 14'h0888, "R11");
    prot_cfg = 2'b11;
    put(13'h0403, 14'h0999, "R10");
    prot_cfg = 2'b01;
    put(13'h0FF3, 14'h0123, "R11");
    put(13'h1003, 14'h0124, "R11");
    prot_cfg = 2'b00;
    put(13'h1F00, 14'h2222, "R11");
    put(13'h1F03, 14'h2223, "R11");
    prot_cfg = 2'b11;
    put(13'h1F01, 14'h3333, "R11");
    put(13'h1F03, 14'h3334, "R11");

    // R12: writes ignored during a commit
    set_addr(13'h0503); set_data(14'h1F1F); unlock();
    m_arm = 0;
    m_buf[3] = m_data;
    wr(2'd0, CTRL_OK);
    wr(2'd1, 16'h0600); wr(2'd2, 16'h0001);
    wr(2'd3, 16'h0055); wr(2'd3, 16'h00AA);
    while (wr_busy) @(negedge clk);
    we_exp++;
    erase_model();
    start(CTRL_OK, "R12");
    m_buf[3] = m_data;
    unlock();
    start(CTRL_OK, "R12");

    // random mix
    for (int it = 0; it < 160; it++) begin
      logic [15:0] cv;
      int r;
      r = $urandom_range(0, 9);
      prot_cfg = (r < 7) ? 2'b11 : 2'($urandom_range(0, 3));
      if ($urandom_range(0, 1) == 1) set_addr(13'($urandom));
      else set_addr({m_addr[ADDR_W-1:2], 2'($urandom_range(0, 3))});
      set_data(14'($urandom));
      r = $urandom_range(0, 9);
      if (r < 7) unlock();
      else if (r == 7) begin key(8'h55); key(8'($urandom)); end
      else key(8'($urandom));
      cv = ($urandom_range(0, 4) != 0) ? CTRL_OK : 16'($urandom_range(0, 15));
      start(cv, "R7");
    end

    done = 1;
    summary();
  end
endmodule